// File: doc/BRIEF.md
# IR Remote Carrier Timing Generator

This block produces the timing for an infrared remote transmitter. It divides a fast oscillator clock into a 50% duty carrier, by 8 or by 12. It then divides that carrier again into a slower reference period, tau. A one-shot ON-time timer counts whole tau periods. While it runs, it gates the carrier onto the transmit output and holds a data-envelope output high. When the programmed count has elapsed, it issues a single-clock completion strobe.

Software selects the carrier and tau ratios and enables the carrier and/or envelope path. It then writes a 4-bit ON time and pulses a start input. The timer arms and begins counting at the next tau boundary, so every ON period is a whole number of tau periods. A force bit drives the carrier and envelope outputs active without the timer, for software-timed transmission. Both dividers are held cleared while neither enable is set, so the first tau period after enabling has full length.

Top module: `ir_carrier_timer`

## Requirements
- R1: After reset, car_out, dcar_out, tau_out and irq are 0 and tau_sel_q reads 2'b00.
- R2: The raw carrier has a period of 8 clocks when car_div_sel is 0 and 12 clocks when it is 1. It is high for exactly half the period. It is observable on car_out with sw_force set.
- R3: While car_en or dcar_en is 1, tau_out has a period of the carrier period times 12, 16, 20 or 32 for tau_sel_q codes 00, 01, 10 and 11. It is high for exactly half of that period.
- R4: While car_en and dcar_en are both 0, tau_out stays 0. While sw_force is also 0, car_out stays 0.
- R5: A write strobe on tau_sel_we loads tau_sel_wdata into tau_sel_q only while both enables are 0. While either enable is 1 the write is ignored, and both tau_sel_q and the tau period keep their old values.
- R6: With car_en set, a start pulse with on_time N from 1 to 15 waits for the next tau rising edge. It then gates the carrier onto car_out for exactly N tau periods, which is N times the tau ratio carrier rising edges on car_out. A start pulse is ignored while the timer is already busy or while both enables are 0.
- R7: A start pulse with on_time 0 produces no carrier pulse on car_out and no envelope on dcar_out. It issues the completion strobe at the next tau rising edge.
- R8: Each accepted start produces exactly one irq pulse, one clock wide, at the end of the ON time.
- R9: With dcar_en set, dcar_out is high for exactly N tau periods during a run with on_time N, which is N times the carrier divide times the tau ratio in clocks.
- R10: While sw_force is 1, dcar_out is 1 and car_out follows the raw carrier, whatever the enable bits or the timer are doing. With both enables 0, tau_out still stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_div_sel | input | 1 | Carrier divide select: 0 gives /8, 1 gives /12 |
| tau_sel_wdata | input | 2 | New tau ratio code |
| tau_sel_we | input | 1 | Write strobe for the tau ratio code |
| on_time | input | 4 | ON time in tau periods, 0 to 15 |
| on_start | input | 1 | Start pulse for the ON-time timer |
| car_en | input | 1 | Carrier path enable |
| dcar_en | input | 1 | Data-envelope path enable |
| sw_force | input | 1 | Force carrier and envelope outputs active |
| car_out | output | 1 | Gated carrier output |
| dcar_out | output | 1 | Data-envelope output |
| tau_out | output | 1 | Tau reference waveform |
| tau_sel_q | output | 2 | Currently held tau ratio code |
| irq | output | 1 | One-clock completion strobe |

## Verification
The hardest case to reach is the exact edge at which the ON window opens and closes. That edge is also a carrier rising edge, so a one-off error there changes the pulse count by one. The stimulus starts runs at random phases relative to tau, with random ratios and ON times. For each run it counts car_out rising edges, dcar_out high clocks and irq pulses until well after the strobe. Directed cases cover ON time 0, a locked tau-ratio write while enabled, and forcing with the dividers disabled.

// File: rtl/ir_carrier_timer.sv
module ir_carrier_timer #(
  parameter int ON_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            car_div_sel,
  input  logic [1:0]      tau_sel_wdata,
  input  logic            tau_sel_we,
  input  logic [ON_W-1:0] on_time,
  input  logic            on_start,
  input  logic            car_en,
  input  logic            dcar_en,
  input  logic            sw_force,
  output logic            car_out,
  output logic            dcar_out,
  output logic            tau_out,
  output logic [1:0]      tau_sel_q,
  output logic            irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_ACTIVE} tmr_state_t;

  logic            run, car_run;
  logic [3:0]      osc_cnt, car_half;
  logic            carrier, car_flip, car_rise;
  logic [4:0]      tau_cnt, tau_half;
  logic            tau_q, tau_tick;
  tmr_state_t      state;
  logic [ON_W-1:0] on_cnt;

  assign run      = car_en | dcar_en;
  assign car_run  = run | sw_force;
  assign car_half = car_div_sel ? 4'd6 : 4'd4;
  assign car_flip = car_run && (osc_cnt >= car_half - 4'd1);
  assign car_rise = car_flip && !carrier;

  always_comb begin
    case (tau_sel_q)
      2'b00:   tau_half = 5'd6;
      2'b01:   tau_half = 5'd8;
      2'b10:   tau_half = 5'd10;
      default: tau_half = 5'd16;
    endcase
  end

  assign tau_tick = run && car_rise && !tau_q && (tau_cnt >= tau_half - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_cnt <= '0;
      carrier <= 1'b0;
    end else if (!car_run) begin
      osc_cnt <= '0;
      carrier <= 1'b0;
    end else if (car_flip) begin
      osc_cnt <= '0;
      carrier <= ~carrier;
    end else begin
      osc_cnt <= osc_cnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tau_cnt <= '0;
      tau_q   <= 1'b0;
    end else if (!run) begin
      tau_cnt <= '0;
      tau_q   <= 1'b0;
    end else if (car_rise) begin
      if (tau_cnt >= tau_half - 5'd1) begin
        tau_cnt <= '0;
        tau_q   <= ~tau_q;
      end else begin
        tau_cnt <= tau_cnt + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tau_sel_q <= 2'b00;
    else if (tau_sel_we && !run)
      tau_sel_q <= tau_sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      on_cnt <= '0;
      irq    <= 1'b0;
    end else if (!run) begin
      state  <= ST_IDLE;
      on_cnt <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: if (on_start) begin
          on_cnt <= on_time;
          state  <= ST_ARMED;
        end
        ST_ARMED: if (tau_tick) begin
          if (on_cnt == '0) begin
            irq   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: if (tau_tick) begin
          if (on_cnt == ON_W'(1)) begin
            irq    <= 1'b1;
            on_cnt <= '0;
            state  <= ST_IDLE;
          end else begin
            on_cnt <= on_cnt - ON_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign car_out  = carrier & ((car_en & (state == ST_ACTIVE)) | sw_force);
  assign dcar_out = sw_force | (dcar_en & (state == ST_ACTIVE));
  assign tau_out  = tau_q;

endmodule

// File: rtl/ir_carrier_timer_chk.sv
module ir_carrier_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       car_en,
  input logic       dcar_en,
  input logic       sw_force,
  input logic       car_out,
  input logic       dcar_out,
  input logic       tau_out,
  input logic [1:0] tau_sel_q,
  input logic       irq
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R8
  AST_TAU_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(car_en || dcar_en) |=> !tau_out); // R4
  AST_CAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(car_en || dcar_en || sw_force) |=> !car_out); // R4
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (car_en || dcar_en) |=> $stable(tau_sel_q)); // R5
  AST_FORCE_DCAR: assert property (@(posedge clk) disable iff (!rst_n) sw_force |-> dcar_out); // R10
  AST_CAR_GATE: assert property (@(posedge clk) disable iff (!rst_n) car_out |-> (car_en || sw_force)); // R6

endmodule

bind ir_carrier_timer ir_carrier_timer_chk chk_i (.*);

// File: tb/ir_carrier_timer_tb_top.sv
module ir_carrier_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       car_div_sel = 1'b0;
  logic [1:0] tau_sel_wdata = 2'b00;
  logic       tau_sel_we = 1'b0;
  logic [3:0] on_time = 4'd0;
  logic       on_start = 1'b0;
  logic       car_en = 1'b0;
  logic       dcar_en = 1'b0;
  logic       sw_force = 1'b0;
  logic       car_out, dcar_out, tau_out, irq;
  logic [1:0] tau_sel_q;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ir_carrier_timer dut_i (
    .clk(clk), .rst_n(rst_n), .car_div_sel(car_div_sel),
    .tau_sel_wdata(tau_sel_wdata), .tau_sel_we(tau_sel_we),
    .on_time(on_time), .on_start(on_start), .car_en(car_en),
    .dcar_en(dcar_en), .sw_force(sw_force), .car_out(car_out),
    .dcar_out(dcar_out), .tau_out(tau_out), .tau_sel_q(tau_sel_q), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int car_div(input bit s);
    return s ? 12 : 8;
  endfunction

  function automatic int tau_div(input logic [1:0] c);
    case (c)
      2'b00: return 12;
      2'b01: return 16;
      2'b10: return 20;
      default: return 32;
    endcase
  endfunction

  function automatic logic sig(input int w);
    return (w == 0) ? car_out : tau_out;
  endfunction

  task automatic meas(input int w, output int per, output int hi);
    int g = 0;
    per = 0; hi = 0;
    while (sig(w) !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
    while (sig(w) !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
    while (sig(w) === 1'b1 && g < 4000) begin @(negedge clk); hi++; g++; end
    per = hi;
    while (sig(w) === 1'b0 && g < 4000) begin @(negedge clk); per++; g++; end
  endtask

  task automatic idle_all();
    car_en = 1'b0; dcar_en = 1'b0; sw_force = 1'b0; on_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_tau(input logic [1:0] c);
    tau_sel_wdata = c; tau_sel_we = 1'b1;
    @(negedge clk);
    tau_sel_we = 1'b0;
  endtask

  task automatic run_on(input bit ds, input logic [1:0] ts, input int n, input bit use_d, input int skew);
    int rises = 0, dhi = 0, irqs = 0, g = 0, post = 0;
    logic prev = 1'b0;
    idle_all();
    car_div_sel = ds;
    set_tau(ts);
    on_time = 4'(n);
    car_en = 1'b1; dcar_en = use_d;
    repeat (skew) @(negedge clk);
    on_start = 1'b1;
    @(negedge clk);
    on_start = 1'b0;
    while (post < 40 && g < 20000) begin
      if (car_out && !prev) rises++;
      prev = car_out;
      if (dcar_out) dhi++;
      if (irq) irqs++;
      if (irqs > 0) post++;
      if (irqs > 0 && post == 20) begin
        on_start = 1'b1;
      end else begin
        on_start = 1'b0;
      end
      @(negedge clk); g++;
    end
    if (n == 0) begin
      chk("R7 car rises", rises, 0);
      chk("R7 dcar high", dhi, 0);
      chk("R7 irq count", irqs, 1);
    end else begin
      chk("R6 car rises", rises, n * tau_div(ts));
      chk("R9 dcar high clocks", dhi, use_d ? n * car_div(ds) * tau_div(ts) : 0);
      chk("R8 irq count", irqs, 1);
    end
    idle_all();
  endtask

  initial begin
    int per, hi, bad;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 car_out", car_out, 0);
    chk("R1 dcar_out", dcar_out, 0);
    chk("R1 tau_out", tau_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tau_sel_q", tau_sel_q, 0);
    rst_n = 1'b1;
    @(negedge clk);

    bad = 0;
    repeat (200) begin @(negedge clk); if (tau_out || car_out) bad++; end
    chk("R4 idle outputs", bad, 0);

    for (int s = 0; s < 2; s++) begin
      idle_all();
      car_div_sel = s[0]; sw_force = 1'b1;
      meas(0, per, hi);
      chk("R2 carrier period", per, car_div(s[0]));
      chk("R2 carrier high", hi, car_div(s[0]) / 2);
    end

    idle_all();
    car_div_sel = 1'b0; sw_force = 1'b1;
    bad = 0;
    repeat (500) begin @(negedge clk); if (tau_out) bad++; if (!dcar_out) bad++; end
    chk("R10 force dcar high, tau idle", bad, 0);
    meas(0, per, hi);
    chk("R10 forced carrier period", per, 8);

    for (int c = 0; c < 4; c++) begin
      idle_all();
      car_div_sel = c[0];
      set_tau(2'(c));
      chk("R5 tau_sel_q loads while idle", tau_sel_q, c);
      car_en = 1'b1;
      meas(1, per, hi);
      chk("R3 tau period", per, car_div(c[0]) * tau_div(2'(c)));
      chk("R3 tau high", hi, car_div(c[0]) * tau_div(2'(c)) / 2);
    end

    idle_all();
    car_div_sel = 1'b0;
    set_tau(2'b00);
    dcar_en = 1'b1;
    @(negedge clk);
    set_tau(2'b11);
    chk("R5 locked tau_sel_q", tau_sel_q, 0);
    meas(1, per, hi);
    chk("R5 locked tau period", per, 8 * 12);

    run_on(1'b0, 2'b00, 0, 1'b1, 0);
    run_on(1'b1, 2'b11, 0, 1'b0, 7);
    run_on(1'b0, 2'b00, 1, 1'b1, 0);
    run_on(1'b1, 2'b11, 15, 1'b1, 3);

    for (int k = 0; k < 12; k++) begin
      run_on(1'($urandom), 2'($urandom), int'($urandom % 16), 1'($urandom), int'($urandom % 200));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule